// File: doc/BRIEF.md
# Flash Read Status Multiplexer

This block builds the byte a flash device returns on each read. In normal operation it returns the word read from the array. While an internal program cycle is running, it returns a polling word instead. In that word, bit 7 is the inverse of bit 7 of the last byte written, and bit 6 flips on every read. Host software can poll either bit to find out when the cycle has finished. In identification mode it returns fixed vendor and device codes, and also a lock-status byte for each of the two boot blocks.

A read is a rising edge of `rd_stb`, seen on a rising edge of `clk`. The returned byte is registered on that edge and stays on `rd_data` until the next read. Holding the strobe high does not count as further reads. A polling cycle has priority over identification mode.

Top module: `flash_rd_status_mux`

## Requirements
- R1: After synchronous reset, `rd_data` is 8'h00 and the internal toggle bit is 0, so the first busy read returns bit 6 = 0.
- R2: With `busy` low and `id_mode` low, a read captures `arr_data` unchanged into `rd_data`.
- R3: With `busy` high, a read returns bit 7 equal to the inverse of `last_byte[7]`.
- R4: With `busy` high, bit 6 of the first read after `busy` rises is 0, and bit 6 alternates on every later read. This also holds when the read falls on the same clock edge on which `busy` rises.
- R5: With `busy` high, bits 5 to 0 of a read are `arr_data[5:0]`.
- R6: Only the rising edge of `rd_stb` makes a read. While the strobe is held high or is low, `rd_data` holds its value and the toggle bit does not advance.
- R7: Once `busy` falls, reads return true array data on all eight bits, and bit 6 no longer alternates.
- R8: In identification mode with `busy` low, address 0 returns 8'h1F and address 1 returns 8'hDA.
- R9: In identification mode, address 2 returns the lower boot-block lock status. The all-ones address minus 13 (18'h3FFF2 by default) returns the upper boot-block status. The status byte is 8'hFF when the block is locked and 8'hFE when it is not.
- R10: In identification mode, any other address returns 8'h00. While `busy` is high, the polling word is returned even if `id_mode` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_stb | input | 1 | Read strobe; each rising edge is one read |
| addr | input | ADDR_W (18) | Byte address of the read |
| arr_data | input | 8 | Word read from the array at `addr` |
| busy | input | 1 | Program cycle in progress |
| last_byte | input | 8 | Last byte loaded for programming |
| id_mode | input | 1 | Identification mode active |
| lock_lo | input | 1 | Lower boot block is locked |
| lock_hi | input | 1 | Upper boot block is locked |
| rd_data | output | 8 | Registered read value |

## Verification
The only internal state is the toggle bit and the two edge-history flops. A wrong toggle state shows up in bit 6 of the very next busy read, either as a repeated value or as a wrong first value after `busy` rises. A stuck strobe-history flop shows up as extra or missing captures. These appear on the first held strobe or on the read that follows it. The bench therefore checks reads one after another, including a read on the same edge on which `busy` rises and a read after a held strobe.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    localparam logic [7:0] MFR_CODE  = 8'h1F;
    localparam logic [7:0] DEV_CODE  = 8'hDA;
    localparam logic [7:0] LOCK_OPEN = 8'hFE;
    localparam logic [7:0] LOCK_SET  = 8'hFF;
    localparam logic [7:0] ID_NONE   = 8'h00;

    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_POLL  = 2'd1,
        SRC_IDENT = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic       inv7;
        logic       tgl;
        logic [5:0] low;
    } poll_word_t;

    function automatic logic [7:0] lock_byte(input logic locked);
        return locked ? LOCK_SET : LOCK_OPEN;
    endfunction

endpackage

// File: rtl/flash_rd_edges.sv
module flash_rd_edges (
    input  logic clk,
    input  logic rst,
    input  logic rd_stb,
    input  logic busy,
    output logic rd_rise,
    output logic busy_start
);
    logic stb_q;
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            stb_q  <= rd_stb;
            busy_q <= busy;
        end
    end

    assign rd_rise    = rd_stb & ~stb_q;
    assign busy_start = busy & ~busy_q;

    // R6
    held_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_rise);
endmodule

// File: rtl/flash_rd_toggle.sv
module flash_rd_toggle (
    input  logic clk,
    input  logic rst,
    input  logic rd_rise,
    input  logic busy,
    input  logic busy_start,
    output logic tgl_now
);
    logic tgl;

    assign tgl_now = busy_start ? 1'b0 : tgl;

    always_ff @(posedge clk) begin
        if (rst)
            tgl <= 1'b0;
        else if (busy && rd_rise)
            tgl <= ~tgl_now;
        else
            tgl <= tgl_now;
    end

    // R4
    first_poll_tgl_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_start && rd_rise) |=> tgl);
    // R4
    tgl_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_rise && !busy_start) |=> (tgl != $past(tgl)));
    // R6
    tgl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_rise && !busy_start) |=> $stable(tgl));
endmodule

// File: rtl/flash_rd_ident.sv
module flash_rd_ident
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output logic [7:0]        id_byte
);
    localparam logic [ADDR_W-1:0] A_MFR     = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DEV     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_LOCK_LO = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_LOCK_HI = ~ADDR_W'(13);

    always_comb begin
        if (addr == A_MFR)
            id_byte = MFR_CODE;
        else if (addr == A_DEV)
            id_byte = DEV_CODE;
        else if (addr == A_LOCK_LO)
            id_byte = lock_byte(lock_lo);
        else if (addr == A_LOCK_HI)
            id_byte = lock_byte(lock_hi);
        else
            id_byte = ID_NONE;
    end
endmodule

// File: rtl/flash_rd_status_mux.sv
module flash_rd_status_mux
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        arr_data,
    input  logic              busy,
    input  logic [7:0]        last_byte,
    input  logic              id_mode,
    input  logic              lock_lo,
    input  logic              lock_hi,
    output logic [7:0]        rd_data
);
    logic       rd_rise;
    logic       busy_start;
    logic       tgl_now;
    logic [7:0] id_byte;
    rd_src_e    src;
    poll_word_t poll;
    logic [7:0] next_val;

    flash_rd_edges u_edges (
        .clk        (clk),
        .rst        (rst),
        .rd_stb     (rd_stb),
        .busy       (busy),
        .rd_rise    (rd_rise),
        .busy_start (busy_start)
    );

    flash_rd_toggle u_toggle (
        .clk        (clk),
        .rst        (rst),
        .rd_rise    (rd_rise),
        .busy       (busy),
        .busy_start (busy_start),
        .tgl_now    (tgl_now)
    );

    flash_rd_ident #(.ADDR_W(ADDR_W)) u_ident (
        .addr    (addr),
        .lock_lo (lock_lo),
        .lock_hi (lock_hi),
        .id_byte (id_byte)
    );

    always_comb begin
        if (busy)
            src = SRC_POLL;
        else if (id_mode)
            src = SRC_IDENT;
        else
            src = SRC_ARRAY;
    end

    always_comb begin
        poll.inv7 = ~last_byte[7];
        poll.tgl  = tgl_now;
        poll.low  = arr_data[5:0];
    end

    always_comb begin
        unique case (src)
            SRC_POLL:  next_val = poll;
            SRC_IDENT: next_val = id_byte;
            default:   next_val = arr_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= 8'h00;
        else if (rd_rise)
            rd_data <= next_val;
    end

    // R3
    poll_bit7_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_rise) |=> (rd_data[7] == ~$past(last_byte[7])));
    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_rise |=> $stable(rd_data));
    // R7
    true_data_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !id_mode && rd_rise) |=> (rd_data == $past(arr_data)));
    // R8
    mfr_code_chk: assert property (@(posedge clk) disable iff (rst)
        (id_mode && !busy && rd_rise && addr == '0) |=> (rd_data == MFR_CODE));
endmodule

// File: tb/tb_flash_rd_status_mux.sv
module tb_flash_rd_status_mux;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst;
    logic              rd_stb;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        arr_data;
    logic              busy;
    logic [7:0]        last_byte;
    logic              id_mode;
    logic              lock_lo;
    logic              lock_hi;
    logic [7:0]        rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic mtgl;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_rd_status_mux #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .addr(addr),
        .arr_data(arr_data), .busy(busy), .last_byte(last_byte),
        .id_mode(id_mode), .lock_lo(lock_lo), .lock_hi(lock_hi),
        .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one read: strobe rises at a negedge, captured at the next posedge,
    // checked at the following negedge where strobe drops
    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; arr_data = d; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic set_busy(input logic b);
        @(negedge clk);
        busy = b;
        if (b) mtgl = 1'b0;
    endtask

    function automatic logic [7:0] poll_exp(input logic [7:0] d);
        logic [7:0] v;
        v = {~last_byte[7], mtgl, d[5:0]};
        mtgl = ~mtgl;
        return v;
    endfunction

    task automatic t_reset;
        chk("R1 reset rd_data", rd_data, 8'h00);
    endtask

    task automatic t_idle_read;
        do_read(18'h00123, 8'h5A); chk("R2 array read 5A", rd_data, 8'h5A);
        do_read(18'h3FFFF, 8'hC3); chk("R2 array read C3", rd_data, 8'hC3);
    endtask

    task automatic t_busy_poll;
        logic [7:0] e;
        last_byte = 8'h80;
        set_busy(1'b1);
        do_read(18'h00040, 8'h3F); e = poll_exp(8'h3F);
        chk("R1 R4 first poll toggle 0", rd_data, e);
        do_read(18'h00040, 8'h15); e = poll_exp(8'h15);
        chk("R3 R5 poll word", rd_data, e);
        last_byte = 8'h7F;
        do_read(18'h00040, 8'hAA); e = poll_exp(8'hAA);
        chk("R3 R4 poll inv7 and toggle", rd_data, e);
    endtask

    task automatic t_held_strobe;
        logic [7:0] e;
        @(negedge clk);
        addr = 18'h00041; arr_data = 8'h01; rd_stb = 1'b1;
        @(negedge clk);
        e = poll_exp(8'h01);
        chk("R6 held strobe first capture", rd_data, e);
        arr_data = 8'h3E;
        repeat (4) @(negedge clk);
        chk("R6 held strobe no recapture", rd_data, e);
        rd_stb = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 idle strobe holds", rd_data, e);
        do_read(18'h00041, 8'h02); e = poll_exp(8'h02);
        chk("R6 toggle advanced once", rd_data, e);
    endtask

    task automatic t_busy_end;
        set_busy(1'b0);
        do_read(18'h00041, 8'hE7); chk("R7 true data after busy", rd_data, 8'hE7);
        do_read(18'h00041, 8'hE7); chk("R7 no toggle after busy", rd_data, 8'hE7);
    endtask

    task automatic t_same_edge_start;
        logic [7:0] e;
        last_byte = 8'h00;
        @(negedge clk);
        busy = 1'b1; mtgl = 1'b0;
        addr = 18'h00010; arr_data = 8'hC0; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        e = poll_exp(8'hC0);
        chk("R4 read on busy start edge", rd_data, e);
        do_read(18'h00010, 8'hC0); e = poll_exp(8'hC0);
        chk("R4 next toggle after start edge", rd_data, e);
    endtask

    task automatic t_busy_over_id;
        logic [7:0] e;
        id_mode = 1'b1;
        do_read(18'h00000, 8'h11); e = poll_exp(8'h11);
        chk("R10 busy overrides id mode", rd_data, e);
        set_busy(1'b0);
    endtask

    task automatic t_id_codes;
        id_mode = 1'b1;
        do_read(18'h00000, 8'h99); chk("R8 manufacturer code", rd_data, 8'h1F);
        do_read(18'h00001, 8'h99); chk("R8 device code", rd_data, 8'hDA);
    endtask

    task automatic t_id_lock;
        lock_lo = 1'b0; lock_hi = 1'b1;
        do_read(18'h00002, 8'h00); chk("R9 lower unlocked", rd_data, 8'hFE);
        do_read(18'h3FFF2, 8'h00); chk("R9 upper locked", rd_data, 8'hFF);
        lock_lo = 1'b1; lock_hi = 1'b0;
        do_read(18'h00002, 8'h00); chk("R9 lower locked", rd_data, 8'hFF);
        do_read(18'h3FFF2, 8'h00); chk("R9 upper unlocked", rd_data, 8'hFE);
    endtask

    task automatic t_id_other;
        do_read(18'h00003, 8'h77); chk("R10 id other addr", rd_data, 8'h00);
        do_read(18'h3FFF3, 8'h77); chk("R10 id near upper addr", rd_data, 8'h00);
        id_mode = 1'b0;
        do_read(18'h00003, 8'h77); chk("R2 array after id exit", rd_data, 8'h77);
    endtask

    initial begin
        rst = 1'b1; rd_stb = 1'b0; addr = '0; arr_data = 8'h00; busy = 1'b0;
        last_byte = 8'h00; id_mode = 1'b0; lock_lo = 1'b0; lock_hi = 1'b0;
        mtgl = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_read();
        t_busy_poll();
        t_held_strobe();
        t_busy_end();
        t_same_edge_start();
        t_busy_over_id();
        t_id_codes();
        t_id_lock();
        t_id_other();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule